// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves data between system memory and a storage card data stream under the control of a linked list of descriptors held in memory. It is given a starting list address, a total byte count, a transfer direction, a block size and an enable. When started, it reads each four-word descriptor through a single-request word memory port and moves that descriptor's share of the data. It then hands the descriptor back to software by rewriting its status word. It follows the next pointer to the next descriptor until it reaches one flagged as the final entry.

In the card-bound direction, words read from memory are offered on the transmit stream. In the memory-bound direction, words taken from the receive stream are written to memory. When the chain is finished the engine raises a one-cycle done pulse and latches completion flags for the surrounding interrupt logic.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset `idle_o` is 1, `done_o` is 0, no memory request, no transmit valid and no receive ready are asserted, and `raw_int_o` and `dma_stat_o` are zero.
- R2: A start pulse is ignored unless `total_bytes_i` is nonzero, `block_size_i` is nonzero and `dma_enable_i` is 1, and, for a memory-bound transfer (`dir_write_i` = 0), `card_data_ready_i` is 1. An ignored start issues no memory request, keeps `idle_o` at 1 and leaves `raw_int_o` and `dma_stat_o` unchanged.
- R3: A start pulse while the engine is busy has no effect on the transfer in progress.
- R4: Each descriptor is read as four words at its address plus 0, 4, 8 and 12, in this order: status, buffer size in bytes, buffer address, next descriptor address.
- R5: A buffer size of zero, or one above `MAX_DESC_BYTES` (8192 or 65536), is treated as `MAX_DESC_BYTES`.
- R6: A descriptor moves the smaller of its buffer size and the remaining byte count, as that many bytes rounded up to whole 32-bit words, at consecutive word addresses from its buffer address with bits 1:0 cleared.
- R7: With `dir_write_i` = 1 the memory words are sent on the transmit stream in address order. With `dir_write_i` = 0 the receive stream words are written to memory in arrival order.
- R8: After its data has moved, each descriptor's status word is written back to the descriptor address with bit 31 cleared and every other bit unchanged.
- R9: The remaining count drops by the bytes moved. The chain stops after a descriptor whose status bit 2 is set. Otherwise the next descriptor is fetched from the next-address word, even when no bytes remain.
- R10: On completion `done_o` is high for exactly one cycle, and `idle_o` is high the cycle after. `raw_int_o` bits 3 and 16 and `dma_stat_o` bit 8 are set, and so is `dma_stat_o` bit 0 for a card-bound transfer or bit 1 for a memory-bound one. These flags hold until the next accepted start clears them.
- R11: The memory port keeps a request and its address and data stable until `mem_gnt_i`. It issues no new request while a read awaits `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| dir_write_i | input | 1 | 1: memory to card, 0: card to memory |
| total_bytes_i | input | CNT_W | Total bytes to move |
| block_size_i | input | CNT_W | Card block size, must be nonzero |
| dma_enable_i | input | 1 | Engine enable |
| desc_base_i | input | 32 | Address of the first descriptor |
| card_data_ready_i | input | 1 | Card has read data available |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Memory request accepted |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_data_o | output | 32 | Transmit word |
| tx_ready_i | input | 1 | Card accepts transmit word |
| rx_valid_i | input | 1 | Receive word valid |
| rx_data_i | input | 32 | Receive word |
| rx_ready_o | output | 1 | Engine accepts receive word |
| done_o | output | 1 | One-cycle completion pulse |
| idle_o | output | 1 | Engine idle, start can be accepted |
| raw_int_o | output | 32 | Latched raw completion events |
| dma_stat_o | output | 10 | Latched engine status flags |

## Verification
A corrupted remaining count or descriptor field shows at the memory port within a few cycles. It appears as a read or write at an address the walk of the chain does not predict, or as a word count that ends a buffer early or late. A wrong direction or data path state shows on the first stream handshake as a word out of order. A lost last flag shows as a fetch beyond the chain's end at the very next request. The bench compares every memory handshake, every stream word and the idle flag against its own descriptor walk on every clock, so the first divergent cycle is reported.

// File: rtl/chdma_pkg.sv
`timescale 1ns/1ps
package chdma_pkg;
   localparam int DESC_WORDS = 4;
   // word order inside a descriptor
   localparam int DW_STATUS = 0;
   localparam int DW_SIZE   = 1;
   localparam int DW_BUF    = 2;
   localparam int DW_NEXT   = 3;
   // status bits used by the engine
   localparam int DF_OWN  = 31;
   localparam int DF_LAST = 2;
   // completion flags
   localparam int EV_XFER    = 3;
   localparam int EV_HOSTSIG = 16;
   localparam int DS_TX      = 0;
   localparam int DS_RX      = 1;
   localparam int DS_SUM     = 8;
   localparam int DSTAT_W    = 10;

   typedef enum logic [2:0] {
      EG_IDLE, EG_FETCH, EG_FWAIT, EG_MOVE, EG_WBACK, EG_FINISH
   } eng_state_t;

   typedef enum logic [2:0] {
      MV_IDLE, MV_MREQ, MV_MWAIT, MV_CSEND, MV_CRECV, MV_MWRITE, MV_DONE
   } mv_state_t;

   function automatic logic [31:0] release_own(input logic [31:0] st);
      return st & ~(32'h1 << DF_OWN);
   endfunction
endpackage

// File: rtl/chdma_size_unit.sv
`timescale 1ns/1ps
module chdma_size_unit #(
   parameter int CNT_W     = 32,
   parameter int MAX_BYTES = 8192
) (
   input  logic [31:0]      size_field,
   input  logic [CNT_W-1:0] remaining,
   output logic [CNT_W-1:0] take_bytes,
   output logic [CNT_W-1:0] take_words
);
   localparam logic [31:0] MAX_W32 = 32'(MAX_BYTES);

   logic [31:0]  eff;
   logic [CNT_W:0] eff_x, rem_x, take_x, round_x;

   always_comb begin
      eff        = (size_field == 32'd0 || size_field > MAX_W32) ? MAX_W32 : size_field;
      eff_x      = (CNT_W+1)'(eff);
      rem_x      = {1'b0, remaining};
      take_x     = (eff_x < rem_x) ? eff_x : rem_x;
      round_x    = (take_x + (CNT_W+1)'(3)) >> 2;
      take_bytes = take_x[CNT_W-1:0];
      take_words = round_x[CNT_W-1:0];
   end
endmodule

// File: rtl/chdma_mover.sv
`timescale 1ns/1ps
module chdma_mover
   import chdma_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             dir_wr,
   input  logic [31:0]      base_addr,
   input  logic [CNT_W-1:0] n_words,
   output logic             finished,
   output logic             mreq,
   output logic             mwe,
   output logic [31:0]      maddr,
   output logic [31:0]      mwdata,
   input  logic             mgnt,
   input  logic             mrvalid,
   input  logic [31:0]      mrdata,
   output logic             tx_valid,
   output logic [31:0]      tx_data,
   input  logic             tx_ready,
   input  logic             rx_valid,
   input  logic [31:0]      rx_data,
   output logic             rx_ready
);
   mv_state_t        state_q;
   logic [31:0]      addr_q;
   logic [31:0]      buf_q;
   logic [CNT_W-1:0] left_q;
   logic             last_word;

   assign last_word = (left_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         addr_q  <= '0;
         buf_q   <= '0;
         left_q  <= '0;
      end else begin
         case (state_q)
            MV_IDLE: if (go) begin
               addr_q <= base_addr;
               left_q <= n_words;
               if (n_words == '0)  state_q <= MV_DONE;
               else if (dir_wr)    state_q <= MV_MREQ;
               else                state_q <= MV_CRECV;
            end
            MV_MREQ:  if (mgnt) state_q <= MV_MWAIT;
            MV_MWAIT: if (mrvalid) begin
               buf_q   <= mrdata;
               state_q <= MV_CSEND;
            end
            MV_CSEND: if (tx_ready) begin
               addr_q  <= addr_q + 32'd4;
               left_q  <= left_q - CNT_W'(1);
               state_q <= last_word ? MV_DONE : MV_MREQ;
            end
            MV_CRECV: if (rx_valid) begin
               buf_q   <= rx_data;
               state_q <= MV_MWRITE;
            end
            MV_MWRITE: if (mgnt) begin
               addr_q  <= addr_q + 32'd4;
               left_q  <= left_q - CNT_W'(1);
               state_q <= last_word ? MV_DONE : MV_CRECV;
            end
            MV_DONE:  state_q <= MV_IDLE;
            default:  state_q <= MV_IDLE;
         endcase
      end
   end

   assign finished = (state_q == MV_DONE);
   assign mreq     = (state_q == MV_MREQ) || (state_q == MV_MWRITE);
   assign mwe      = (state_q == MV_MWRITE);
   assign maddr    = addr_q;
   assign mwdata   = buf_q;
   assign tx_valid = (state_q == MV_CSEND);
   assign tx_data  = buf_q;
   assign rx_ready = (state_q == MV_CRECV);
endmodule

// File: rtl/chain_dma_engine.sv
`timescale 1ns/1ps
module chain_dma_engine
   import chdma_pkg::*;
#(
   parameter int MAX_DESC_BYTES = 8192,
   parameter int CNT_W          = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               dir_write_i,
   input  logic [CNT_W-1:0]   total_bytes_i,
   input  logic [CNT_W-1:0]   block_size_i,
   input  logic               dma_enable_i,
   input  logic [31:0]        desc_base_i,
   input  logic               card_data_ready_i,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [31:0]        mem_addr_o,
   output logic [31:0]        mem_wdata_o,
   input  logic               mem_gnt_i,
   input  logic               mem_rvalid_i,
   input  logic [31:0]        mem_rdata_i,
   output logic               tx_valid_o,
   output logic [31:0]        tx_data_o,
   input  logic               tx_ready_i,
   input  logic               rx_valid_i,
   input  logic [31:0]        rx_data_i,
   output logic               rx_ready_o,
   output logic               done_o,
   output logic               idle_o,
   output logic [31:0]        raw_int_o,
   output logic [DSTAT_W-1:0] dma_stat_o
);
   localparam int MAX_LOG2 = $clog2(MAX_DESC_BYTES);
   localparam int IDX_W    = $clog2(DESC_WORDS);

   if (MAX_DESC_BYTES != 8192 && MAX_DESC_BYTES != 65536) begin : g_bad_max
      $error("MAX_DESC_BYTES must be 8192 or 65536");
   end
   if (CNT_W < MAX_LOG2 + 3 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must hold the largest buffer size and fit 32 bits");
   end

   eng_state_t       state_q;
   logic [31:0]      cur_q;
   logic [CNT_W-1:0] rem_q;
   logic             dirw_q;
   logic [IDX_W-1:0] widx_q;
   logic             mv_go_q;
   logic [31:0]      raw_q;
   logic [DSTAT_W-1:0] stat_q;
   logic [31:0]      desc_w [DESC_WORDS];

   logic             accept;
   logic             capture;
   logic [CNT_W-1:0] take_bytes, take_words;
   logic             mv_fin, mv_req, mv_we;
   logic [31:0]      mv_addr, mv_wdata;
   logic             eng_req, eng_we;
   logic [31:0]      eng_addr;

   assign accept = start_i && (state_q == EG_IDLE) && (total_bytes_i != '0) &&
                   (block_size_i != '0) && dma_enable_i &&
                   (dir_write_i || card_data_ready_i);
   assign capture = (state_q == EG_FWAIT) && mem_rvalid_i;

   // one holding register per descriptor word
   for (genvar g = 0; g < DESC_WORDS; g++) begin : g_dw
      logic [31:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     word_q <= '0;
         else if (capture && widx_q == IDX_W'(g))        word_q <= mem_rdata_i;
      end
      assign desc_w[g] = word_q;
   end

   chdma_size_unit #(.CNT_W(CNT_W), .MAX_BYTES(MAX_DESC_BYTES)) u_size (
      .size_field (desc_w[DW_SIZE]),
      .remaining  (rem_q),
      .take_bytes (take_bytes),
      .take_words (take_words)
   );

   chdma_mover #(.CNT_W(CNT_W)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (mv_go_q),
      .dir_wr    (dirw_q),
      .base_addr ({desc_w[DW_BUF][31:2], 2'b00}),
      .n_words   (take_words),
      .finished  (mv_fin),
      .mreq      (mv_req),
      .mwe       (mv_we),
      .maddr     (mv_addr),
      .mwdata    (mv_wdata),
      .mgnt      (mem_gnt_i),
      .mrvalid   (mem_rvalid_i),
      .mrdata    (mem_rdata_i),
      .tx_valid  (tx_valid_o),
      .tx_data   (tx_data_o),
      .tx_ready  (tx_ready_i),
      .rx_valid  (rx_valid_i),
      .rx_data   (rx_data_i),
      .rx_ready  (rx_ready_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EG_IDLE;
         cur_q   <= '0;
         rem_q   <= '0;
         dirw_q  <= 1'b0;
         widx_q  <= '0;
         mv_go_q <= 1'b0;
         raw_q   <= '0;
         stat_q  <= '0;
      end else begin
         case (state_q)
            EG_IDLE: if (accept) begin
               cur_q   <= desc_base_i;
               rem_q   <= total_bytes_i;
               dirw_q  <= dir_write_i;
               widx_q  <= '0;
               raw_q   <= '0;
               stat_q  <= '0;
               state_q <= EG_FETCH;
            end
            EG_FETCH: if (mem_gnt_i) state_q <= EG_FWAIT;
            EG_FWAIT: if (mem_rvalid_i) begin
               if (widx_q == IDX_W'(DESC_WORDS - 1)) begin
                  mv_go_q <= 1'b1;
                  state_q <= EG_MOVE;
               end else begin
                  widx_q  <= widx_q + IDX_W'(1);
                  state_q <= EG_FETCH;
               end
            end
            EG_MOVE: begin
               mv_go_q <= 1'b0;
               if (mv_fin) state_q <= EG_WBACK;
            end
            EG_WBACK: if (mem_gnt_i) begin
               rem_q <= rem_q - take_bytes;
               if (desc_w[DW_STATUS][DF_LAST]) begin
                  raw_q[EV_XFER]    <= 1'b1;
                  raw_q[EV_HOSTSIG] <= 1'b1;
                  stat_q[DS_SUM]    <= 1'b1;
                  if (dirw_q) stat_q[DS_TX] <= 1'b1;
                  else        stat_q[DS_RX] <= 1'b1;
                  state_q <= EG_FINISH;
               end else begin
                  cur_q   <= desc_w[DW_NEXT];
                  widx_q  <= '0;
                  state_q <= EG_FETCH;
               end
            end
            EG_FINISH: state_q <= EG_IDLE;
            default:   state_q <= EG_IDLE;
         endcase
      end
   end

   assign eng_req  = (state_q == EG_FETCH) || (state_q == EG_WBACK);
   assign eng_we   = (state_q == EG_WBACK);
   assign eng_addr = (state_q == EG_FETCH) ? cur_q + 32'({widx_q, 2'b00}) : cur_q;

   assign mem_req_o   = eng_req | mv_req;
   assign mem_we_o    = eng_req ? eng_we : mv_we;
   assign mem_addr_o  = eng_req ? eng_addr : mv_addr;
   assign mem_wdata_o = eng_req ? release_own(desc_w[DW_STATUS]) : mv_wdata;

   assign done_o     = (state_q == EG_FINISH);
   assign idle_o     = (state_q == EG_IDLE);
   assign raw_int_o  = raw_q;
   assign dma_stat_o = stat_q;
endmodule

// File: rtl/chdma_checker.sv
`timescale 1ns/1ps
module chdma_checker
   import chdma_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               mem_req,
   input logic               mem_we,
   input logic [31:0]        mem_addr,
   input logic [31:0]        mem_wdata,
   input logic               mem_gnt,
   input logic               mem_rvalid,
   input logic               tx_valid,
   input logic               tx_ready,
   input logic [31:0]        tx_data,
   input logic               rx_ready,
   input logic               done,
   input logic               idle,
   input logic [31:0]        raw_int,
   input logic [DSTAT_W-1:0] dma_stat
);
   logic rd_pending_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             rd_pending_q <= 1'b0;
      else if (mem_req && !mem_we && mem_gnt) rd_pending_q <= 1'b1;
      else if (mem_rvalid)                    rd_pending_q <= 1'b0;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pending_q |-> !mem_req); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mem_req && !tx_valid && !rx_ready); // R2
   AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      idle && $past(idle) && !$past(start) |-> $stable(raw_int) && $stable(dma_stat)); // R2
   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && idle); // R10
   AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> raw_int[EV_XFER] && raw_int[EV_HOSTSIG] && dma_stat[DS_SUM] && $onehot(dma_stat[1:0])); // R10
   AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_stat[1:0])); // R10
endmodule

bind chain_dma_engine chdma_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start_i),
   .mem_req    (mem_req_o),
   .mem_we     (mem_we_o),
   .mem_addr   (mem_addr_o),
   .mem_wdata  (mem_wdata_o),
   .mem_gnt    (mem_gnt_i),
   .mem_rvalid (mem_rvalid_i),
   .tx_valid   (tx_valid_o),
   .tx_ready   (tx_ready_i),
   .tx_data    (tx_data_o),
   .rx_ready   (rx_ready_o),
   .done       (done_o),
   .idle       (idle_o),
   .raw_int    (raw_int_o),
   .dma_stat   (dma_stat_o)
);

// File: tb/sim_chain_dma_engine.sv
`timescale 1ns/1ps
module sim_chain_dma_engine;
   localparam int unsigned MAXB = 8192;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0, start = 1'b0, dir_wr = 1'b0, dma_en = 1'b0, card_rdy = 1'b0;
   logic [31:0] total = '0, blk = '0, base = '0;
   logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
   logic [31:0] tx_data, rx_data = '0;
   logic        done, idle;
   logic [31:0] raw;
   logic [9:0]  dstat;

   chain_dma_engine #(.MAX_DESC_BYTES(MAXB), .CNT_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dir_write_i(dir_wr),
      .total_bytes_i(total), .block_size_i(blk), .dma_enable_i(dma_en),
      .desc_base_i(base), .card_data_ready_i(card_rdy),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
      .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
      .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
      .rx_ready_o(rx_ready), .done_o(done), .idle_o(idle),
      .raw_int_o(raw), .dma_stat_o(dstat)
   );

   logic [31:0] mem [4096];
   logic [31:0] exp_rd[$];  string exp_rd_tag[$];
   logic [31:0] exp_wa[$];  logic [31:0] exp_wd[$]; string exp_w_tag[$];
   logic [31:0] exp_tx[$];  logic [31:0] rx_src[$];
   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit model_busy = 1'b0, pend_rv = 1'b0, finished = 1'b0;
   logic [31:0] pend_rd = '0;

   function automatic int widx(input logic [31:0] a);
      return int'(a[13:2]);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // memory, card and per-clock comparison against the model
   always @(negedge clk) begin
      cyc++;
      mem_rvalid = pend_rv;
      mem_rdata  = pend_rd;
      pend_rv    = 1'b0;
      mem_gnt    = (cyc % 3 != 1);
      tx_ready   = (cyc % 4 != 2);
      rx_valid   = (cyc % 5 != 3) && (rx_src.size() > 0);
      rx_data    = rx_valid ? rx_src[0] : 32'h0;
      if (rst_n) begin
         chk(idle == !model_busy, "R3 idle window", 32'(idle), 32'(!model_busy));
         if (!model_busy) chk(!mem_req, "R2 no request while idle", 32'(mem_req), 0);
         if (mem_req && mem_gnt) begin
            if (!mem_we) begin
               if (exp_rd.size() == 0) chk(1'b0, "R9 unexpected read", mem_addr, 32'hFFFF_FFFF);
               else begin
                  logic [31:0] ea;
                  string t;
                  ea = exp_rd.pop_front();
                  t  = exp_rd_tag.pop_front();
                  chk(mem_addr == ea, t, mem_addr, ea);
               end
               pend_rv = 1'b1;
               pend_rd = mem[widx(mem_addr)];
            end else begin
               if (exp_wa.size() == 0) chk(1'b0, "R9 unexpected write", mem_addr, 32'hFFFF_FFFF);
               else begin
                  logic [31:0] ea, ed;
                  string t;
                  ea = exp_wa.pop_front();
                  ed = exp_wd.pop_front();
                  t  = exp_w_tag.pop_front();
                  chk(mem_addr == ea, {t, " addr"}, mem_addr, ea);
                  chk(mem_wdata == ed, {t, " data"}, mem_wdata, ed);
               end
               mem[widx(mem_addr)] = mem_wdata;
            end
         end
         if (tx_valid && tx_ready) begin
            if (exp_tx.size() == 0) chk(1'b0, "R7 unexpected tx", tx_data, 32'hFFFF_FFFF);
            else begin
               logic [31:0] et;
               et = exp_tx.pop_front();
               chk(tx_data == et, "R7 tx word", tx_data, et);
            end
         end
         if (rx_valid && rx_ready) void'(rx_src.pop_front());
      end
   end

   task automatic setd(input logic [31:0] a, input logic [31:0] st, input logic [31:0] sz,
                       input logic [31:0] ba, input logic [31:0] nx);
      mem[widx(a)] = st; mem[widx(a+4)] = sz; mem[widx(a+8)] = ba; mem[widx(a+12)] = nx;
   endtask

   // walk the chain from the requirements and build expected traffic
   task automatic build(input logic [31:0] b, input int unsigned t, input bit w);
      logic [31:0] a, st, sz, ba, nx;
      int unsigned rem, eff, take, nw, j;
      exp_rd.delete(); exp_rd_tag.delete(); exp_wa.delete(); exp_wd.delete();
      exp_w_tag.delete(); exp_tx.delete(); rx_src.delete();
      a = b; rem = t; j = 0;
      forever begin
         for (int k = 0; k < 4; k++) begin
            exp_rd.push_back(a + 32'(4*k)); exp_rd_tag.push_back("R4 descriptor read");
         end
         st = mem[widx(a)]; sz = mem[widx(a+4)]; ba = mem[widx(a+8)] & 32'hFFFF_FFFC; nx = mem[widx(a+12)];
         eff  = (sz == 0 || sz > MAXB) ? MAXB : sz;
         take = (eff < rem) ? eff : rem;
         nw   = (take + 3) / 4;
         for (int unsigned k = 0; k < nw; k++) begin
            logic [31:0] wa;
            wa = ba + 32'(4*k);
            if (w) begin
               exp_rd.push_back(wa); exp_rd_tag.push_back("R5/R6 buffer read");
               exp_tx.push_back(mem[widx(wa)]);
            end else begin
               rx_src.push_back(32'hD000_0000 + j);
               exp_wa.push_back(wa); exp_wd.push_back(32'hD000_0000 + j);
               exp_w_tag.push_back("R6/R7 buffer write");
               j++;
            end
         end
         exp_wa.push_back(a); exp_wd.push_back(st & 32'h7FFF_FFFF);
         exp_w_tag.push_back("R8 status write-back");
         rem -= take;
         if (st[2]) break;
         a = nx;
      end
   endtask

   task automatic run(input logic [31:0] b, input int unsigned t, input bit w, input bit extra);
      bit seen;
      build(b, t, w);
      @(negedge clk);
      base = b; total = t; blk = 32'd512; dir_wr = w; dma_en = 1'b1; card_rdy = 1'b1; start = 1'b1;
      @(posedge clk); #1 start = 1'b0; model_busy = 1'b1;
      @(negedge clk);
      chk(raw == 0 && dstat == 0, "R10 flags cleared on start", raw | 32'(dstat), 0);
      seen = 1'b0;
      for (int c = 0; c < 40000 && !seen; c++) begin
         @(negedge clk);
         if (extra && c == 15) begin start = 1'b1; dir_wr = ~w; base = 32'h0; total = 32'd4; end
         if (extra && c == 16) start = 1'b0;
         if (done) seen = 1'b1;
      end
      if (!seen) chk(1'b0, "R10 transfer watchdog", 0, 1);
      else begin
         chk(raw == 32'h0001_0008, "R10 raw flags", raw, 32'h0001_0008);
         chk(dstat == (10'h100 | (w ? 10'h1 : 10'h2)), "R10 status flags", 32'(dstat),
             32'(10'h100 | (w ? 10'h1 : 10'h2)));
         chk(exp_rd.size() + exp_wa.size() + exp_tx.size() + rx_src.size() == 0,
             "R9 R5 chain fully consumed",
             32'(exp_rd.size() + exp_wa.size() + exp_tx.size() + rx_src.size()), 0);
      end
      #1 model_busy = 1'b0;
      @(negedge clk);
      chk(!done, "R10 done is one cycle", 32'(done), 0);
   endtask

   task automatic ign(input int unsigned t, input logic [31:0] bk, input bit en, input bit w, input bit rdy);
      logic [31:0] prev_raw;
      logic [9:0]  prev_st;
      prev_raw = raw; prev_st = dstat;
      @(negedge clk);
      base = 32'h0; total = t; blk = bk; dma_en = en; dir_wr = w; card_rdy = rdy; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (6) @(negedge clk);
      chk(idle, "R2 start ignored", 32'(idle), 1);
      chk(raw == prev_raw && dstat == prev_st, "R2 flags unchanged", raw, prev_raw);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0001_0203);
      setd(32'h000, 32'h8000_000C, 32'd12,    32'h100, 32'h0);
      setd(32'h020, 32'h8000_0018, 32'd8,     32'h203, 32'h040);
      setd(32'h040, 32'h8000_0010, 32'd16,    32'h240, 32'h060);
      setd(32'h060, 32'hC000_0006, 32'd64,    32'h280, 32'h0);
      setd(32'h080, 32'h8000_0018, 32'd12,    32'h300, 32'h0A0);
      setd(32'h0A0, 32'h8000_0004, 32'd100,   32'h340, 32'h0);
      setd(32'h0C0, 32'h8000_0010, 32'd16,    32'h380, 32'h0E0);
      setd(32'h0E0, 32'h8000_0004, 32'd8,     32'h3C0, 32'h0);
      setd(32'h800, 32'h8000_000C, 32'd0,     32'h1000, 32'h0);
      setd(32'h820, 32'h8000_0018, 32'd20000, 32'h1000, 32'h840);
      setd(32'h840, 32'h8000_0004, 32'd4,     32'h3000, 32'h0);

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(idle && !done, "R1 idle after reset", {30'h0, idle, done}, 32'h2);
      chk(!mem_req && !tx_valid && !rx_ready, "R1 quiet ports", 32'({mem_req, tx_valid, rx_ready}), 0);
      chk(raw == 0 && dstat == 0, "R1 flags zero", raw | 32'(dstat), 0);

      ign(0, 512, 1'b1, 1'b1, 1'b1);   // R2 zero byte count
      ign(16, 0, 1'b1, 1'b1, 1'b1);    // R2 zero block size
      ign(16, 512, 1'b0, 1'b1, 1'b1);  // R2 engine disabled
      ign(16, 512, 1'b1, 1'b0, 1'b0);  // R2 read with no card data

      run(32'h000, 12, 1'b1, 1'b0);    // single descriptor, card-bound
      run(32'h020, 34, 1'b1, 1'b1);    // R3 R6 chain, masked address, 10-byte tail
      ign(16, 512, 1'b1, 1'b0, 1'b0);  // R2 flags kept after completion
      run(32'h080, 30, 1'b0, 1'b0);    // R7 memory-bound chain
      run(32'h0C0, 16, 1'b1, 1'b0);    // R9 continue with nothing left
      run(32'h800, 8200, 1'b1, 1'b0);  // R5 zero size means maximum
      run(32'h820, 8196, 1'b0, 1'b1);  // R5 oversized entry clamped

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule